// File: doc/BRIEF.md
# Single Wait-State Bus Clock Stretcher

This block makes the processor bus clock from a free-running oscillator whose frequency is the unstretched processor rate. The design runs on a fabric clock `clk` at twice the oscillator rate, so each `clk` period is one oscillator half-period. The oscillator therefore appears as a phase that toggles on every `clk` edge. If no wait is requested, the bus clock follows the oscillator: one half-period low, then one half-period high.

The wait request is sampled once per bus cycle, on the oscillator rising edge that ends the low phase. If it is set there, the high phase is held through the next full oscillator period, so it lasts three half-periods in place of one. The stretch flag clears after that single extension, so back-to-back slow accesses each get exactly one wait state.

Two active-low write strobes are produced from the read/write line, which is captured when the clock rises. The fast strobe goes low with the clock rise on any write and stays low for the whole high phase. The slow strobe stays inactive during the first high half-period and goes low only when the stretch begins. It then ends together with the high phase. A fast write is therefore never held back by the stretch decision. All outputs come from registers, so the bus clock cannot glitch.

Top module: `bus_clk_stretch`

## Requirements
- R1: While `rst` is high, `cpu_clk` is 0 and both `wr_fast_n` and `wr_slow_n` are 1. The first bus cycle after reset starts with a low half-period.
- R2: With `wait_req` low at the sampling edge, the high phase of `cpu_clk` lasts exactly one `clk` period and the next low phase follows at once.
- R3: With `wait_req` high at the `clk` edge where `cpu_clk` rises, the high phase lasts exactly three `clk` periods.
- R4: `wait_req` has no effect at any edge other than the one where `cpu_clk` rises. A request raised or dropped during a high or low phase changes neither that phase nor the current bus cycle.
- R5: `rd_wr_n` = 0 means write and 1 means read; it is sampled at the edge where `cpu_clk` rises. On a write, `wr_fast_n` falls at that same edge and stays 0 until `cpu_clk` falls.
- R6: On a stretched write, `wr_slow_n` is 1 in the first high period and 0 in the second and third. On an unstretched write it stays 1.
- R7: On a read cycle neither strobe goes low, stretched or not.
- R8: With `wait_req` held high for many cycles, every high phase lasts exactly three periods, never more.
- R9: Every low phase of `cpu_clk` lasts exactly one `clk` period, so the clock changes only twice per bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, one period per oscillator half-period |
| rst | input | 1 | Synchronous active-high reset |
| wait_req | input | 1 | Wait-state request, sampled when the bus clock rises |
| rd_wr_n | input | 1 | Processor read/write line, 1 read, 0 write |
| cpu_clk | output | 1 | Stretchable processor bus clock |
| wr_fast_n | output | 1 | Active-low write strobe for fast devices |
| wr_slow_n | output | 1 | Active-low delayed write strobe for slow devices |

## Verification
The hardest case to reach is a request that changes just after the sampling edge. It is dropped inside the first high period, or raised during a stretch or a low phase. This case shows whether the block samples only at the edge where the clock rises. The stimulus drives `wait_req` and `rd_wr_n` fresh on every falling edge of `clk` from a random source, so requests land on all four phases of a bus cycle. Separate phases then hold the request high for many cycles to produce back-to-back stretches, and run reads only.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    // Position inside one bus cycle; each step is one oscillator half-period.
    typedef enum logic [1:0] {
        PH_LOW    = 2'd0,   // bus clock low, oscillator low
        PH_HIGH   = 2'd1,   // bus clock high, oscillator high
        PH_STR_LO = 2'd2,   // stretch: oscillator low, bus clock held high
        PH_STR_HI = 2'd3    // stretch: oscillator high, last high half-period
    } phase_e;

    typedef struct packed {
        logic fast_n;
        logic slow_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{fast_n: 1'b1, slow_n: 1'b1};

    function automatic logic clk_high(input phase_e ph);
        return ph != PH_LOW;
    endfunction

    function automatic logic in_stretch(input phase_e ph);
        return (ph == PH_STR_LO) || (ph == PH_STR_HI);
    endfunction

endpackage

// File: rtl/bcs_sequencer.sv
module bcs_sequencer
    import bcs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wait_req,
    output phase_e phase_q,
    output phase_e phase_d,
    output logic   stretch_q
);

    logic stretch_d;

    always_comb begin
        phase_d   = phase_q;
        stretch_d = stretch_q;
        unique case (phase_q)
            PH_LOW: begin
                phase_d   = PH_HIGH;
                stretch_d = wait_req;       // the only sampling point
            end
            PH_HIGH:   phase_d = stretch_q ? PH_STR_LO : PH_LOW;
            PH_STR_LO: begin
                phase_d   = PH_STR_HI;
                stretch_d = 1'b0;           // one wait state per request
            end
            PH_STR_HI: phase_d = PH_LOW;
            default:   phase_d = PH_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_LOW;
            stretch_q <= 1'b0;
        end else begin
            phase_q   <= phase_d;
            stretch_q <= stretch_d;
        end
    end

    // R8: no stretch survives into the next bus cycle
    p_stretch_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_STR_HI) |=> (phase_q == PH_LOW) && !stretch_q);

endmodule

// File: rtl/bcs_strobes.sv
module bcs_strobes
    import bcs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rd_wr_n,
    input  phase_e  phase_q,
    input  phase_e  phase_d,
    output strobe_t strobe_q
);

    logic    wr_q;
    logic    wr_d;
    strobe_t strobe_d;

    // Direction is captured as the bus clock rises and held for the cycle.
    always_comb begin
        wr_d            = (phase_q == PH_LOW) ? !rd_wr_n : wr_q;
        strobe_d.fast_n = !(clk_high(phase_d) && wr_d);
        strobe_d.slow_n = !(in_stretch(phase_d) && wr_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q     <= 1'b0;
            strobe_q <= STROBE_IDLE;
        end else begin
            wr_q     <= wr_d;
            strobe_q <= strobe_d;
        end
    end

    // R6: the slow strobe is only active while the fast one is
    p_slow_within_fast_r6: assert property (@(posedge clk) disable iff (rst)
        !strobe_q.slow_n |-> !strobe_q.fast_n);

endmodule

// File: rtl/bus_clk_stretch.sv
module bus_clk_stretch
    import bcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wait_req,
    input  logic rd_wr_n,
    output logic cpu_clk,
    output logic wr_fast_n,
    output logic wr_slow_n
);

    phase_e  phase_q;
    phase_e  phase_d;
    logic    stretch_q;
    strobe_t strobe_q;
    logic    cpu_clk_q;

    bcs_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .wait_req  (wait_req),
        .phase_q   (phase_q),
        .phase_d   (phase_d),
        .stretch_q (stretch_q)
    );

    bcs_strobes u_stb (
        .clk      (clk),
        .rst      (rst),
        .rd_wr_n  (rd_wr_n),
        .phase_q  (phase_q),
        .phase_d  (phase_d),
        .strobe_q (strobe_q)
    );

    // Registered output: the clock seen outside never carries a decode glitch.
    always_ff @(posedge clk) begin
        if (rst) cpu_clk_q <= 1'b0;
        else     cpu_clk_q <= clk_high(phase_d);
    end

    assign cpu_clk   = cpu_clk_q;
    assign wr_fast_n = strobe_q.fast_n;
    assign wr_slow_n = strobe_q.slow_n;

    // R1: reset idles every output
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> !cpu_clk && wr_fast_n && wr_slow_n);

    // R2: an unrequested high phase lasts one period
    p_plain_high_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk) && !$past(wait_req) |=> !cpu_clk);

    // R3: a requested high phase continues for two more periods
    p_stretched_high_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk) && $past(wait_req) |=> cpu_clk ##1 cpu_clk);

    // R5: fast strobe follows the sampled direction at the clock rise
    p_fast_at_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk) |-> (wr_fast_n == $past(rd_wr_n)));

    // R6: slow strobe is never active in the first high period
    p_slow_late_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk) |-> wr_slow_n);

    // R8: never more than three high periods in a row
    p_high_max_r8: assert property (@(posedge clk) disable iff (rst)
        cpu_clk && $past(cpu_clk) && $past(cpu_clk, 2) |=> !cpu_clk);

    // R9: a low phase is always one period long
    p_low_one_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_clk) |=> cpu_clk);

endmodule

// File: tb/sim_bus_clk_stretch.sv
module sim_bus_clk_stretch;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wait_req = 1'b0;
    logic rd_wr_n = 1'b1;
    logic cpu_clk, wr_fast_n, wr_slow_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    bus_clk_stretch u0 (
        .clk(clk), .rst(rst), .wait_req(wait_req), .rd_wr_n(rd_wr_n),
        .cpu_clk(cpu_clk), .wr_fast_n(wr_fast_n), .wr_slow_n(wr_slow_n)
    );

    // Behavioural reference: position counts half-periods in the bus cycle.
    int pos = 0;
    bit m_long = 0;
    bit m_write = 0;
    bit m_late_req = 0;   // request changed away from the sampling edge

    always @(posedge clk) begin
        if (rst) begin
            pos = 0; m_long = 0; m_write = 0;
        end else if (pos == 0) begin
            pos = 1; m_long = wait_req; m_write = !rd_wr_n; m_late_req = 0;
        end else begin
            if (wait_req != m_long) m_late_req = 1;
            if (pos == 1)      pos = m_long ? 2 : 0;
            else if (pos == 2) pos = 3;
            else               pos = 0;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison and port-level run statistics.
    int run = 0, run_min = 99, run_max = 0, runs = 0, strobe_lows = 0;
    always @(negedge clk) begin
        if (!done) begin
            if (rst) begin
                check("R1 cpu_clk", cpu_clk, 1'b0);
                check("R1 wr_fast_n", wr_fast_n, 1'b1);
                check("R1 wr_slow_n", wr_slow_n, 1'b1);
            end else begin
                check(m_late_req ? "R4 cpu_clk" : (m_long ? "R3 cpu_clk" : "R2 cpu_clk"),
                      cpu_clk, pos != 0);
                check("R5 wr_fast_n", wr_fast_n, !(pos != 0 && m_write));
                check("R6 wr_slow_n", wr_slow_n, !(pos >= 2 && m_write));
            end
            if (!wr_fast_n || !wr_slow_n) strobe_lows++;
            if (cpu_clk) run++;
            else if (run > 0) begin
                if (run < run_min) run_min = run;
                if (run > run_max) run_max = run;
                runs++;
                run = 0;
            end
        end
    end

    task automatic stats_clear();
        while (cpu_clk !== 1'b0) @(negedge clk);
        run_min = 99; run_max = 0; runs = 0; strobe_lows = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;

        // R2: no requests, mixed direction
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            rd_wr_n = $urandom_range(0, 1);
        end

        // R4/R3/R5/R6: request and direction change at random phases
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            wait_req = $urandom_range(0, 1);
            rd_wr_n  = $urandom_range(0, 1);
        end

        // R8: held request gives back-to-back single wait states
        @(negedge clk); wait_req = 1; rd_wr_n = 0;
        stats_clear();
        repeat (80) @(negedge clk);
        checks++;
        if (run_min != 3 || run_max != 3 || runs < 15) begin
            errors++;
            $display("FAIL R8 run min %0d max %0d (count %0d) expected 3 3", run_min, run_max, runs);
        end

        // R7: reads never strobe, stretched or not
        @(negedge clk); rd_wr_n = 1;
        repeat (6) @(negedge clk);
        stats_clear();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            wait_req = $urandom_range(0, 1);
        end
        checks++;
        if (strobe_lows != 0) begin
            errors++;
            $display("FAIL R7 strobe low count actual %0d expected 0", strobe_lows);
        end

        // R9: unrequested cycles give exactly one-period highs and lows
        @(negedge clk); wait_req = 0;
        repeat (6) @(negedge clk);
        stats_clear();
        repeat (40) @(negedge clk);
        checks++;
        if (run_min != 1 || run_max != 1) begin
            errors++;
            $display("FAIL R9 run min %0d max %0d expected 1 1", run_min, run_max);
        end

        // R1: reset in the middle of a stretched write
        @(negedge clk); wait_req = 1; rd_wr_n = 0;
        repeat (5) @(negedge clk);
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        repeat (20) @(negedge clk);

        finish_run();
    end

endmodule